// File: doc/BRIEF.md
# Dual-View Audio Block Ring Buffer

This block moves audio samples between converters and a host processor without involving the processor in each sample. On the capture side, every sample from the analog-to-digital converter is written into a circular input ring. The ring is divided into fixed-size blocks. When the last sample of a block lands, a one-cycle interrupt pulse tells the host that a new block is complete. On the playback side, the host deposits blocks into a circular output ring, and a sample reader drains them toward the audio output stage. If the reader is asked for a sample when no committed block is waiting, the block raises a sticky underrun flag.

The host sees each ring through two address views over the same storage. The normal view is a plain physical window, so the newest block moves around the ring as blocks arrive. The smart view rotates the window: logical block 0 is always the newest complete capture block (on the output ring, the next block to be filled), and logical block k sits k blocks behind it. This lets a time-domain filter address its history at constant offsets.

The defaults are 16-bit samples, 4 samples per block and 8 blocks per ring. A host address is split into a block field in bits [4:2] and a sample offset in bits [1:0]. Reset is synchronous and active high.

Top module: `afs_dual_view_fifo`

## Requirements
- R1: After reset, `in_blk_ready`, `dac_valid` and `out_underrun` are 0. Both rings read as zero, and no capture block counts as complete.
- R2: Each accepted capture sample (`adc_valid`=1) is stored at physical address fill_block*4 + fill_offset. The offset counts 0..3, then fill_block advances by one. After block 7 it wraps to block 0 and overwrites the oldest data.
- R3: `in_blk_ready` is high for exactly one cycle, in the cycle after the fourth sample of a block is accepted.
- R4: A host capture read with `hin_smart`=0 returns the word at physical address `hin_addr` (block in bits [4:2], offset in bits [1:0]) on `hin_rdata` one cycle after `hin_re`.
- R5: A host capture read with `hin_smart`=1 treats bits [4:2] as k. It returns the word at offset bits [1:0] of physical block (newest − k) mod 8, one cycle later. Here newest is the most recently completed block.
- R6: A smart capture read whose k is not less than the number of completed blocks (which saturates at 8) returns 0. This includes k=0 before the first block completes.
- R7: A host output write (`hout_we`) with `hout_smart`=0 stores at physical address `hout_addr`. With `hout_smart`=1 it stores at offset bits [1:0] of physical block (next − k) mod 8, where next is the block the host is filling.
- R8: A write that lands on offset 3 of the next block commits that block: next advances by one and the pending count rises by one, provided fewer than 8 blocks are pending. When 8 are pending, the data is still stored but nothing is committed.
- R9: When at least one block is pending, `dac_req` makes the next sample of the oldest committed block appear on `dac_sample` with `dac_valid`=1 one cycle later. After the fourth sample of a block, that block stops being pending.
- R10: `dac_req` with no block pending gives `dac_valid`=0 and `dac_sample`=0 in the next cycle. It also sets `out_underrun`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adc_valid | input | 1 | Capture sample strobe |
| adc_sample | input | 16 | Capture sample |
| in_blk_ready | output | 1 | One-cycle pulse when a capture block completes |
| hin_re | input | 1 | Host capture-ring read enable |
| hin_smart | input | 1 | Host capture read view: 0 normal, 1 smart |
| hin_addr | input | 5 | Host capture read address (block/k in [4:2], offset in [1:0]) |
| hin_rdata | output | 16 | Host capture read data, one cycle after hin_re |
| hout_we | input | 1 | Host output-ring write enable |
| hout_smart | input | 1 | Host output write view: 0 normal, 1 smart |
| hout_addr | input | 5 | Host output write address (block/k in [4:2], offset in [1:0]) |
| hout_wdata | input | 16 | Host output write data |
| dac_req | input | 1 | Output stage requests one sample |
| dac_valid | output | 1 | Output sample valid, one cycle after dac_req |
| dac_sample | output | 16 | Output sample (0 when not valid) |
| out_underrun | output | 1 | Sticky underrun flag |

## Verification
On every cycle, the assertions check the following:
- the ready pulse coincides with a one-step advance of the fill block;
- the fill position holds while no sample arrives;
- the completed-block and pending counts stay within the ring;
- the output fill block is frozen while the ring is full;
- an empty-ring request yields an invalid sample and a set flag;
- the underrun flag never clears on its own.

Only the bench scenarios can show that data lands at the right addresses and comes back through both views. They cover partial, single-block, exactly-full and wrapped capture histories, rotated smart-view writes on the output side, and a write into a full output ring overwriting the oldest unread block without committing.

// File: rtl/afs_pkg.sv
package afs_pkg;
    typedef enum logic {
        VIEW_NORMAL = 1'b0,
        VIEW_SMART  = 1'b1
    } view_e;
endpackage

// File: rtl/afs_ring_ram.sv
module afs_ring_ram #(
    parameter int W     = 16,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];
    logic [W-1:0] rdata_q;

    // read-before-write: a same-cycle read returns the previous word
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rdata_q <= '0;
        end else begin
            if (we) mem_q[waddr] <= wdata;
            if (re) rdata_q <= mem_q[raddr];
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/afs_view_xlat.sv
module afs_view_xlat #(
    parameter int BLOCKS = 8,
    parameter int BLOCK  = 4,
    parameter int BW     = 3,
    parameter int OW     = 2,
    parameter int PAW    = 5
) (
    input  logic                 smart,
    input  logic [BW+OW-1:0]     addr,
    input  logic [BW-1:0]        base_blk,
    output logic [PAW-1:0]       phys_addr
);
    import afs_pkg::*;

    localparam bit POW2 = (BLOCKS & (BLOCKS - 1)) == 0;

    view_e         mode;
    logic [BW-1:0] k;
    logic [OW-1:0] off;
    logic [BW-1:0] rot;
    logic [BW-1:0] blk;

    assign mode = smart ? VIEW_SMART : VIEW_NORMAL;
    assign k    = addr[BW+OW-1:OW];
    assign off  = addr[OW-1:0];

    generate
        if (POW2) begin : g_pow2
            assign rot = base_blk - k;
        end else begin : g_any
            logic [BW:0] wide;
            assign wide = {1'b0, base_blk} + (BW+1)'(BLOCKS) - {1'b0, k};
            assign rot  = (k > base_blk) ? wide[BW-1:0] : base_blk - k;
        end
    endgenerate

    assign blk       = (mode == VIEW_SMART) ? rot : k;
    assign phys_addr = PAW'(blk) * PAW'(BLOCK) + PAW'(off);
endmodule

// File: rtl/afs_in_ctrl.sv
module afs_in_ctrl #(
    parameter int BLOCKS = 8,
    parameter int BLOCK  = 4,
    parameter int BW     = 3,
    parameter int OW     = 2,
    parameter int PAW    = 5,
    parameter int CW     = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           adc_valid,
    input  logic           rd_req,
    input  logic           rd_smart,
    input  logic [BW-1:0]  rd_k,
    output logic           wr_en,
    output logic [PAW-1:0] wr_addr,
    output logic [BW-1:0]  newest_blk,
    output logic           blk_ready,
    output logic           rd_zero
);
    typedef struct packed {
        logic [BW-1:0] fill_blk;
        logic [OW-1:0] fill_off;
        logic [CW-1:0] done_cnt;
        logic          ready;
        logic          rd_zero;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ready   = 1'b0;
        st_d.rd_zero = rd_req && rd_smart && (CW'(rd_k) >= st_q.done_cnt);
        if (adc_valid) begin
            if (st_q.fill_off == OW'(BLOCK - 1)) begin
                st_d.fill_off = '0;
                st_d.fill_blk = (st_q.fill_blk == BW'(BLOCKS - 1)) ? '0
                              : st_q.fill_blk + BW'(1);
                st_d.ready    = 1'b1;
                if (st_q.done_cnt != CW'(BLOCKS))
                    st_d.done_cnt = st_q.done_cnt + CW'(1);
            end else begin
                st_d.fill_off = st_q.fill_off + OW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign wr_en      = adc_valid;
    assign wr_addr    = PAW'(st_q.fill_blk) * PAW'(BLOCK) + PAW'(st_q.fill_off);
    assign newest_blk = (st_q.fill_blk == '0) ? BW'(BLOCKS - 1) : st_q.fill_blk - BW'(1);
    assign blk_ready  = st_q.ready;
    assign rd_zero    = st_q.rd_zero;

    // R3: the ready pulse comes from an accepted sample and a one-step block advance
    a_r3_ready_advance: assert property (@(posedge clk) disable iff (rst)
        st_q.ready |-> ($past(adc_valid) &&
            st_q.fill_blk == (($past(st_q.fill_blk) == BW'(BLOCKS - 1)) ? '0
                              : $past(st_q.fill_blk) + BW'(1))));
    // R2: no sample, no movement of the fill position
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !adc_valid |=> ($stable(st_q.fill_blk) && $stable(st_q.fill_off)));
    // R6: completed-block count saturates at the ring size
    a_r6_done_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.done_cnt <= CW'(BLOCKS));
endmodule

// File: rtl/afs_out_ctrl.sv
module afs_out_ctrl #(
    parameter int BLOCKS = 8,
    parameter int BLOCK  = 4,
    parameter int BW     = 3,
    parameter int OW     = 2,
    parameter int PAW    = 5,
    parameter int CW     = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_we,
    input  logic [PAW-1:0] host_phys,
    input  logic           dac_req,
    output logic [BW-1:0]  next_blk,
    output logic           rd_en,
    output logic [PAW-1:0] rd_addr,
    output logic           dac_valid,
    output logic           underrun
);
    typedef struct packed {
        logic [BW-1:0] wblk;
        logic [BW-1:0] rblk;
        logic [OW-1:0] roff;
        logic [CW-1:0] pend;
        logic          valid;
        logic          underrun;
    } out_st_t;

    out_st_t st_d, st_q;

    logic           commit;
    logic           consume;
    logic           drain;
    logic [PAW-1:0] last_addr;

    always_comb begin
        last_addr = PAW'(st_q.wblk) * PAW'(BLOCK) + PAW'(BLOCK - 1);
        commit    = host_we && (host_phys == last_addr) && (st_q.pend != CW'(BLOCKS));
        consume   = dac_req && (st_q.pend != '0);
        drain     = consume && (st_q.roff == OW'(BLOCK - 1));

        st_d       = st_q;
        st_d.valid = consume;
        if (dac_req && st_q.pend == '0) st_d.underrun = 1'b1;
        if (consume) begin
            if (drain) begin
                st_d.roff = '0;
                st_d.rblk = (st_q.rblk == BW'(BLOCKS - 1)) ? '0 : st_q.rblk + BW'(1);
            end else begin
                st_d.roff = st_q.roff + OW'(1);
            end
        end
        if (commit)
            st_d.wblk = (st_q.wblk == BW'(BLOCKS - 1)) ? '0 : st_q.wblk + BW'(1);
        case ({commit, drain})
            2'b10:   st_d.pend = st_q.pend + CW'(1);
            2'b01:   st_d.pend = st_q.pend - CW'(1);
            default: st_d.pend = st_q.pend;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign next_blk  = st_q.wblk;
    assign rd_en     = consume;
    assign rd_addr   = PAW'(st_q.rblk) * PAW'(BLOCK) + PAW'(st_q.roff);
    assign dac_valid = st_q.valid;
    assign underrun  = st_q.underrun;

    // R8: pending count never exceeds the ring
    a_r8_pend_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.pend <= CW'(BLOCKS));
    // R8: a full ring freezes the host fill block
    a_r8_full_freeze: assert property (@(posedge clk) disable iff (rst)
        (st_q.pend == CW'(BLOCKS)) |=> $stable(st_q.wblk));
    // R10: request on an empty ring gives no sample and raises the flag
    a_r10_empty_req: assert property (@(posedge clk) disable iff (rst)
        (dac_req && st_q.pend == '0) |=> (!st_q.valid && st_q.underrun));
    // R10: the flag is sticky until reset
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        st_q.underrun |=> st_q.underrun);
endmodule

// File: rtl/afs_dual_view_fifo.sv
module afs_dual_view_fifo #(
    parameter int SAMPLE_W = 16,
    parameter int BLOCK    = 4,
    parameter int BLOCKS   = 8,
    localparam int BW      = $clog2(BLOCKS),
    localparam int OW      = $clog2(BLOCK),
    localparam int HAW     = BW + OW,
    localparam int DEPTH   = BLOCKS * BLOCK,
    localparam int PAW     = $clog2(DEPTH),
    localparam int CW      = $clog2(BLOCKS + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                adc_valid,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                in_blk_ready,
    input  logic                hin_re,
    input  logic                hin_smart,
    input  logic [HAW-1:0]      hin_addr,
    output logic [SAMPLE_W-1:0] hin_rdata,
    input  logic                hout_we,
    input  logic                hout_smart,
    input  logic [HAW-1:0]      hout_addr,
    input  logic [SAMPLE_W-1:0] hout_wdata,
    input  logic                dac_req,
    output logic                dac_valid,
    output logic [SAMPLE_W-1:0] dac_sample,
    output logic                out_underrun
);
    logic                in_we;
    logic [PAW-1:0]      in_waddr;
    logic [BW-1:0]       in_newest;
    logic                in_zero;
    logic [PAW-1:0]      in_raddr;
    logic [SAMPLE_W-1:0] in_rdata;

    logic [BW-1:0]       out_next;
    logic [PAW-1:0]      out_waddr;
    logic                out_re;
    logic [PAW-1:0]      out_raddr;
    logic [SAMPLE_W-1:0] out_rdata;

    afs_in_ctrl #(.BLOCKS(BLOCKS), .BLOCK(BLOCK), .BW(BW), .OW(OW), .PAW(PAW), .CW(CW)) in_ctrl_i (
        .clk(clk), .rst(rst), .adc_valid(adc_valid),
        .rd_req(hin_re), .rd_smart(hin_smart), .rd_k(hin_addr[HAW-1:OW]),
        .wr_en(in_we), .wr_addr(in_waddr), .newest_blk(in_newest),
        .blk_ready(in_blk_ready), .rd_zero(in_zero)
    );

    afs_view_xlat #(.BLOCKS(BLOCKS), .BLOCK(BLOCK), .BW(BW), .OW(OW), .PAW(PAW)) in_xlat_i (
        .smart(hin_smart), .addr(hin_addr), .base_blk(in_newest), .phys_addr(in_raddr)
    );

    afs_ring_ram #(.W(SAMPLE_W), .DEPTH(DEPTH), .AW(PAW)) in_ram_i (
        .clk(clk), .rst(rst), .we(in_we), .waddr(in_waddr), .wdata(adc_sample),
        .re(hin_re), .raddr(in_raddr), .rdata(in_rdata)
    );

    assign hin_rdata = in_zero ? '0 : in_rdata;

    afs_view_xlat #(.BLOCKS(BLOCKS), .BLOCK(BLOCK), .BW(BW), .OW(OW), .PAW(PAW)) out_xlat_i (
        .smart(hout_smart), .addr(hout_addr), .base_blk(out_next), .phys_addr(out_waddr)
    );

    afs_out_ctrl #(.BLOCKS(BLOCKS), .BLOCK(BLOCK), .BW(BW), .OW(OW), .PAW(PAW), .CW(CW)) out_ctrl_i (
        .clk(clk), .rst(rst), .host_we(hout_we), .host_phys(out_waddr),
        .dac_req(dac_req), .next_blk(out_next), .rd_en(out_re), .rd_addr(out_raddr),
        .dac_valid(dac_valid), .underrun(out_underrun)
    );

    afs_ring_ram #(.W(SAMPLE_W), .DEPTH(DEPTH), .AW(PAW)) out_ram_i (
        .clk(clk), .rst(rst), .we(hout_we), .waddr(out_waddr), .wdata(hout_wdata),
        .re(out_re), .raddr(out_raddr), .rdata(out_rdata)
    );

    assign dac_sample = dac_valid ? out_rdata : '0;

    // R9: a valid output sample always follows a request
    a_r9_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        dac_valid |-> $past(dac_req));
endmodule

// File: tb/afs_dual_view_fifo_tb_top.sv
`timescale 1ns/1ps
module afs_dual_view_fifo_tb_top;
    localparam int SW = 16, BLK = 4, NB = 8, DEPTH = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst = 1'b1;
    logic          adc_valid = 0, hin_re = 0, hin_smart = 0, hout_we = 0, hout_smart = 0, dac_req = 0;
    logic [SW-1:0] adc_sample = '0, hout_wdata = '0;
    logic [4:0]    hin_addr = '0, hout_addr = '0;
    logic          in_blk_ready, dac_valid, out_underrun;
    logic [SW-1:0] hin_rdata, dac_sample;

    afs_dual_view_fifo dut_i (
        .clk(clk), .rst(rst), .adc_valid(adc_valid), .adc_sample(adc_sample),
        .in_blk_ready(in_blk_ready), .hin_re(hin_re), .hin_smart(hin_smart),
        .hin_addr(hin_addr), .hin_rdata(hin_rdata), .hout_we(hout_we),
        .hout_smart(hout_smart), .hout_addr(hout_addr), .hout_wdata(hout_wdata),
        .dac_req(dac_req), .dac_valid(dac_valid), .dac_sample(dac_sample),
        .out_underrun(out_underrun)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [SW-1:0] in_m [DEPTH];
    logic [SW-1:0] out_m [DEPTH];
    int in_cnt = 0;
    int ow = 0, orb = 0, oro = 0, opend = 0;
    bit und_m = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic adc_push(input logic [SW-1:0] v);
        adc_valid = 1; adc_sample = v;
        @(negedge clk);
        adc_valid = 0;
        in_m[in_cnt % DEPTH] = v;
        in_cnt++;
        check("R3 block ready pulse", in_blk_ready, (in_cnt % BLK) == 0);
    endtask

    task automatic host_read(input bit smart, input int addr, output logic [SW-1:0] d);
        hin_re = 1; hin_smart = smart; hin_addr = addr[4:0];
        @(negedge clk);
        hin_re = 0;
        d = hin_rdata;
    endtask

    // R4 normal view and R5/R6 smart view, over the whole window
    task automatic sweep();
        logic [SW-1:0] d;
        int blocks, dn, newest;
        blocks = in_cnt / BLK;
        dn = (blocks > NB) ? NB : blocks;
        newest = (blocks + NB - 1) % NB;
        for (int a = 0; a < DEPTH; a++) begin
            host_read(0, a, d);
            check("R4 normal read", d, in_m[a]);
        end
        for (int k = 0; k < NB; k++)
            for (int o = 0; o < BLK; o++) begin
                host_read(1, k * BLK + o, d);
                if (k < dn) check("R5 smart read", d, in_m[((newest - k + NB) % NB) * BLK + o]);
                else        check("R6 smart read empty", d, 0);
            end
    endtask

    task automatic host_write(input bit smart, input int addr, input logic [SW-1:0] v);
        int blk, p;
        blk = smart ? (ow - addr / BLK + NB) % NB : addr / BLK;
        p = blk * BLK + addr % BLK;
        out_m[p] = v;
        if (p == ow * BLK + BLK - 1 && opend < NB) begin
            ow = (ow + 1) % NB;
            opend++;
        end
        hout_we = 1; hout_smart = smart; hout_addr = addr[4:0]; hout_wdata = v;
        @(negedge clk);
        hout_we = 0;
    endtask

    task automatic dac_pull();
        bit ev;
        logic [SW-1:0] es;
        if (opend > 0) begin
            ev = 1; es = out_m[orb * BLK + oro];
            oro++;
            if (oro == BLK) begin oro = 0; orb = (orb + 1) % NB; opend--; end
        end else begin
            ev = 0; es = '0; und_m = 1;
        end
        dac_req = 1;
        @(negedge clk);
        dac_req = 0;
        check(ev ? "R9 valid" : "R10 valid", dac_valid, ev);
        check(ev ? "R9 sample" : "R10 sample", dac_sample, es);
        check("R10 underrun flag", out_underrun, und_m);
    endtask

    initial begin
        logic [SW-1:0] d;
        for (int i = 0; i < DEPTH; i++) begin in_m[i] = '0; out_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", in_blk_ready, 0);
        check("R1 dac_valid", dac_valid, 0);
        check("R1 underrun", out_underrun, 0);
        host_read(0, 5, d);
        check("R1 ring cleared", d, 0);
        // R6 partial first block: smart k=0 still zero
        adc_push(16'h1000); adc_push(16'h1001);
        host_read(1, 0, d);
        check("R6 smart k0 before first block", d, 0);
        adc_push(16'h1002); adc_push(16'h1003);
        sweep();
        // R2 fill, wrap and overwrite over several histories
        for (int i = 4; i < 12; i++) adc_push(16'h1000 + i[15:0]);
        sweep();
        for (int i = 12; i < 32; i++) adc_push(16'h1000 + i[15:0]);
        sweep();
        for (int i = 32; i < 46; i++) adc_push(16'h1000 + i[15:0]);
        sweep();
        // R7/R8 output ring: normal view, smart view, rotated smart write
        for (int o = 0; o < BLK; o++) host_write(0, o, 16'h2000 + o[15:0]);
        for (int o = 0; o < BLK; o++) host_write(1, o, 16'h2100 + o[15:0]);
        host_write(1, BLK * 2 + 1, 16'h2BAD);   // k=2 from block 2 -> block 0 offset 1
        for (int o = BLK - 1; o >= 0; o--) host_write(1, o, 16'h2200 + o[15:0]);
        for (int i = 0; i < 3 * BLK; i++) dac_pull();
        // R8 fill to full, then a write that must not commit
        for (int b = 0; b < NB; b++)
            for (int o = 0; o < BLK; o++) host_write(1, o, 16'h3000 + b[15:0] * 16 + o[15:0]);
        host_write(0, ow * BLK + BLK - 1, 16'hDEAD);
        check("R8 full ring pending", opend, NB);
        for (int i = 0; i < NB * BLK; i++) dac_pull();
        // R10 underrun and stickiness
        dac_pull();
        for (int o = 0; o < BLK; o++) host_write(0, ow * BLK + o, 16'h4000 + o[15:0]);
        for (int i = 0; i < BLK; i++) dac_pull();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule